// File: doc/BRIEF.md
# Edge-Skipping Macroblock Filter Scheduler

This block sequences the deblocking work for one 4:2:0 macroblock. After a start pulse it spends a fixed load window, then walks the 48 block edges and issues one command per edge to an external one-dimensional edge filter. Each command carries the edge number, its plane (luma, Cb or Cr), its direction and its boundary strength. A horizontal edge that needs no filtering is removed from the walk and costs no cycles. Such an edge either has strength zero or sits on the top row of a macroblock in the top row of the frame.

Because removed edges shift the timing of everything after them, the block also drives the strobes and word address for a 32-word left-neighbour store. Reads fetch the previous macroblock's right column while the leftmost vertical edges are filtered. Writes save this macroblock's right column once each rightmost 4x4 block has had its last scheduled edge. A filter clock-enable is high only while the macroblock is in progress. A one-cycle done pulse closes the macroblock and reports the number of busy cycles, so the throughput can be measured.

The boundary strengths and the top-of-frame flag must be held steady from the start pulse until done.

Top module: `deblk_sched`

## Requirements
- R1: While reset is held, and in the first cycles after it, `cmd_valid_o`, `filt_en_o`, `done_o`, `left_rd_o` and `left_wr_o` are all low.
- R2: A start pulse seen while idle raises `filt_en_o` on the next cycle. Four load cycles with no command and no memory strobe follow. The first command appears on the fifth busy cycle.
- R3: Edges are numbered `idx = base + 2*blk + dir`. The plane bases are luma 0, Cb 32 and Cr 40. `blk` counts 4x4 blocks in raster order (4 wide for luma, 2 wide for chroma). `dir` is 0 for vertical and 1 for horizontal. `plane_o` is 0 for luma, 1 for Cb and 2 for Cr. Commands are issued in increasing `idx`, so luma comes before Cb and Cb before Cr, and in each block the vertical edge comes before the horizontal edge.
- R4: A horizontal edge is never issued if its strength is 0, or if `top_frame_i` is high and its block is in row 0. It takes no cycles.
- R5: A vertical edge is always issued, even at strength 0, and `bs_o` reports its strength. The strength of edge `idx` is `bs_i[3*idx +: 3]`.
- R6: Each issued edge occupies exactly four cycles. `cmd_valid_o` is high only in the first of them, and the edge fields hold through all four.
- R7: When done pulses, `cycles_o` equals 4 + 4 x (number of issued edges). That is 196 with no skips and 100 with all 24 horizontal edges skipped.
- R8: `done_o` is high for one cycle, on the cycle after the last slot ends. `filt_en_o` is low in that same cycle.
- R9: A start pulse that arrives while a macroblock is in progress is ignored. It changes neither the schedule nor the state after done.
- R10: During every slot of a vertical edge in block column 0, `left_rd_o` is high in all four cycles. The address is `plane_base + 4*row + phase`, with word bases luma 0, Cb 16 and Cr 24, and `phase` is 0..3 within the slot.
- R11: `left_wr_o` is high in all four cycles of the last scheduled edge of each rightmost-column block, with the same address map. That edge is the block's horizontal edge, or its vertical edge when the horizontal edge is skipped. Read and write are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one macroblock (accepted only when idle) |
| top_frame_i | input | 1 | Macroblock lies in the top row of the frame |
| bs_i | input | 144 | Boundary strength per edge, 3 bits each, indexed by edge number |
| cmd_valid_o | output | 1 | One-cycle command strobe at the start of an edge slot |
| edge_idx_o | output | 6 | Edge number of the current slot |
| plane_o | output | 2 | 0 luma, 1 Cb, 2 Cr |
| dir_o | output | 1 | 0 vertical, 1 horizontal |
| bs_o | output | 3 | Strength of the current edge |
| left_rd_o | output | 1 | Left-neighbour store read strobe |
| left_wr_o | output | 1 | Left-neighbour store write strobe |
| left_addr_o | output | 5 | Left-neighbour store word address |
| filt_en_o | output | 1 | Filter clock-enable, high while busy |
| done_o | output | 1 | One-cycle end-of-macroblock pulse |
| cycles_o | output | 9 | Busy cycles used by the last macroblock |

## Verification
A wrong edge pointer or a wrong skip decision shows on the next command strobe, at most four cycles later. The bench sees it as a wrong edge number, plane or strength, and as a `cycles_o` total that is off by a multiple of four at done. A phase counter that slips shows as a command strobe off the four-cycle grid, or as a read or write address that is off within the slot. A missed lookahead on the block's skipped horizontal edge shows as a right-column write that is missing or misplaced in the same slot.

// File: rtl/deblk_sched_pkg.sv
package deblk_sched_pkg;

  typedef enum logic [1:0] {
    PL_LUMA = 2'd0,
    PL_CB   = 2'd1,
    PL_CR   = 2'd2
  } plane_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_EDGE = 2'd2
  } sched_st_e;

endpackage

// File: rtl/deblk_skip_chk.sv
module deblk_skip_chk #(
  parameter int LS     = 4,
  parameter int BS_W   = 3,
  parameter int N_EDGE = 48,
  parameter int IDX_W  = 6
) (
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [N_EDGE*BS_W-1:0] bs_i,
  input  logic                   top_frame_i,
  output logic                   skip_o
);
  localparam int CS      = LS / 2;
  localparam int CB_BASE = 2 * LS * LS;
  localparam int CR_BASE = CB_BASE + 2 * CS * CS;

  always_comb begin
    int i, loc, row;
    logic [BS_W-1:0] b;
    i      = int'(idx_i);
    loc    = 0;
    row    = 0;
    b      = '0;
    skip_o = 1'b0;
    if (i < N_EDGE) begin
      b = BS_W'(bs_i >> (i * BS_W));
      if (i < CB_BASE) begin
        loc = i;
        row = (loc / 2) / LS;
      end else if (i < CR_BASE) begin
        loc = i - CB_BASE;
        row = (loc / 2) / CS;
      end else begin
        loc = i - CR_BASE;
        row = (loc / 2) / CS;
      end
      // only horizontal edges may leave the schedule
      skip_o = (loc % 2 == 1) && ((b == '0) || (top_frame_i && row == 0));
    end
  end
endmodule

// File: rtl/deblk_edge_map.sv
module deblk_edge_map
  import deblk_sched_pkg::*;
#(
  parameter int LS     = 4,
  parameter int BS_W   = 3,
  parameter int N_EDGE = 48,
  parameter int IDX_W  = 6,
  parameter int RW     = 2
) (
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [N_EDGE*BS_W-1:0] bs_i,
  output plane_e                 plane_o,
  output logic [RW-1:0]          row_o,
  output logic                   dir_o,
  output logic                   first_col_o,
  output logic                   last_col_o,
  output logic [BS_W-1:0]        bs_o
);
  localparam int CS      = LS / 2;
  localparam int CB_BASE = 2 * LS * LS;
  localparam int CR_BASE = CB_BASE + 2 * CS * CS;

  always_comb begin
    int i, loc, side, blk;
    i    = int'(idx_i);
    loc  = 0;
    side = LS;
    if (i < CB_BASE) begin
      plane_o = PL_LUMA;
      loc     = i;
      side    = LS;
    end else if (i < CR_BASE) begin
      plane_o = PL_CB;
      loc     = i - CB_BASE;
      side    = CS;
    end else begin
      plane_o = PL_CR;
      loc     = i - CR_BASE;
      side    = CS;
    end
    blk         = loc / 2;
    dir_o       = (loc % 2 == 1);
    row_o       = RW'(blk / side);
    first_col_o = (blk % side == 0);
    last_col_o  = (blk % side == side - 1);
    bs_o        = (i < N_EDGE) ? BS_W'(bs_i >> (i * BS_W)) : '0;
  end
endmodule

// File: rtl/deblk_left_mem_ctrl.sv
module deblk_left_mem_ctrl
  import deblk_sched_pkg::*;
#(
  parameter int LS   = 4,
  parameter int RW   = 2,
  parameter int PH_W = 2,
  parameter int LA_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic [PH_W-1:0] phase_i,
  input  plane_e          plane_i,
  input  logic [RW-1:0]   row_i,
  input  logic            dir_i,
  input  logic            first_col_i,
  input  logic            last_col_i,
  input  logic            h_skip_next_i,
  output logic            rd_o,
  output logic            wr_o,
  output logic [LA_W-1:0] addr_o
);
  localparam int BLK_ROWS = 4;
  localparam int CS       = LS / 2;
  localparam int CB_WBASE = BLK_ROWS * LS;
  localparam int CR_WBASE = CB_WBASE + BLK_ROWS * CS;

  logic row_phase;

  always_comb begin
    int base;
    row_phase = active_i && (int'(phase_i) < BLK_ROWS);
    // column-0 blocks fetch the left neighbour on their vertical edge
    rd_o = row_phase && !dir_i && first_col_i;
    // right column is final after the block's last scheduled edge
    wr_o = row_phase && last_col_i && (dir_i || h_skip_next_i);
    case (plane_i)
      PL_CB:   base = CB_WBASE;
      PL_CR:   base = CR_WBASE;
      default: base = 0;
    endcase
    addr_o = LA_W'(base + int'(row_i) * BLK_ROWS + int'(phase_i));
  end

  a_r11_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

endmodule

// File: rtl/deblk_cycle_ctr.sv
module deblk_cycle_ctr #(
  parameter int CNT_W = 9,
  parameter int MAX   = 196
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + CNT_W'(1);
  end

  a_r7_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_o) <= MAX);

endmodule

// File: rtl/deblk_sched.sv
module deblk_sched
  import deblk_sched_pkg::*;
#(
  parameter int LS       = 4,
  parameter int BS_W     = 3,
  parameter int SLOT_CYC = 4,
  parameter int LOAD_CYC = 4,
  parameter int CNT_W    = 9
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic                           top_frame_i,
  input  logic [3*LS*LS*BS_W-1:0]        bs_i,
  output logic                           cmd_valid_o,
  output logic [$clog2(3*LS*LS+2)-1:0]   edge_idx_o,
  output logic [1:0]                     plane_o,
  output logic                           dir_o,
  output logic [BS_W-1:0]                bs_o,
  output logic                           left_rd_o,
  output logic                           left_wr_o,
  output logic [$clog2(8*LS)-1:0]        left_addr_o,
  output logic                           filt_en_o,
  output logic                           done_o,
  output logic [CNT_W-1:0]               cycles_o
);
  localparam int N_EDGE = 3 * LS * LS;
  localparam int IDX_W  = $clog2(N_EDGE + 2);
  localparam int LA_W   = $clog2(8 * LS);
  localparam int RW     = $clog2(LS);
  localparam int PH_MAX = (SLOT_CYC > LOAD_CYC) ? SLOT_CYC : LOAD_CYC;
  localparam int PH_W   = $clog2(PH_MAX);
  localparam int MAX_CY = LOAD_CYC + SLOT_CYC * N_EDGE;

  sched_st_e        state_q;
  logic [IDX_W-1:0] idx_q, n1, n2, nxt_idx;
  logic [PH_W-1:0]  phase_q;
  logic             done_q;
  logic             nxt_skip, cur_skip, slot_end, fin, accept;

  plane_e           cur_plane;
  logic [RW-1:0]    cur_row;
  logic             cur_dir, cur_first, cur_last;

  assign n1       = idx_q + IDX_W'(1);
  assign n2       = idx_q + IDX_W'(2);
  assign slot_end = (state_q == ST_EDGE) && (phase_q == PH_W'(SLOT_CYC - 1));
  // a skipped horizontal edge is always followed by a vertical one
  assign fin      = (n1 == IDX_W'(N_EDGE)) || (nxt_skip && n2 == IDX_W'(N_EDGE));
  assign nxt_idx  = nxt_skip ? n2 : n1;
  assign accept   = (state_q == ST_IDLE) && start_i;

  deblk_skip_chk #(.LS(LS), .BS_W(BS_W), .N_EDGE(N_EDGE), .IDX_W(IDX_W)) u_skip_nxt (
    .idx_i(n1), .bs_i(bs_i), .top_frame_i(top_frame_i), .skip_o(nxt_skip)
  );

  deblk_skip_chk #(.LS(LS), .BS_W(BS_W), .N_EDGE(N_EDGE), .IDX_W(IDX_W)) u_skip_cur (
    .idx_i(idx_q), .bs_i(bs_i), .top_frame_i(top_frame_i), .skip_o(cur_skip)
  );

  deblk_edge_map #(.LS(LS), .BS_W(BS_W), .N_EDGE(N_EDGE), .IDX_W(IDX_W), .RW(RW)) u_map (
    .idx_i(idx_q), .bs_i(bs_i), .plane_o(cur_plane), .row_o(cur_row),
    .dir_o(cur_dir), .first_col_o(cur_first), .last_col_o(cur_last), .bs_o(bs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      phase_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LOAD;
          idx_q   <= '0;
          phase_q <= '0;
        end
        ST_LOAD: if (phase_q == PH_W'(LOAD_CYC - 1)) begin
          state_q <= ST_EDGE;
          phase_q <= '0;
        end else begin
          phase_q <= phase_q + PH_W'(1);
        end
        ST_EDGE: if (slot_end) begin
          phase_q <= '0;
          if (fin) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= nxt_idx;
          end
        end else begin
          phase_q <= phase_q + PH_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  deblk_left_mem_ctrl #(.LS(LS), .RW(RW), .PH_W(PH_W), .LA_W(LA_W)) u_left (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .active_i(state_q == ST_EDGE), .phase_i(phase_q),
    .plane_i(cur_plane), .row_i(cur_row), .dir_i(cur_dir),
    .first_col_i(cur_first), .last_col_i(cur_last), .h_skip_next_i(nxt_skip),
    .rd_o(left_rd_o), .wr_o(left_wr_o), .addr_o(left_addr_o)
  );

  deblk_cycle_ctr #(.CNT_W(CNT_W), .MAX(MAX_CY)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept),
    .inc_i(state_q != ST_IDLE), .cnt_o(cycles_o)
  );

  assign cmd_valid_o = (state_q == ST_EDGE) && (phase_q == '0);
  assign edge_idx_o  = idx_q;
  assign plane_o     = cur_plane;
  assign dir_o       = cur_dir;
  assign filt_en_o   = (state_q != ST_IDLE);
  assign done_o      = done_q;

  a_r4_no_skipped_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !cur_skip);
  a_r6_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o && $stable(edge_idx_o));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_en_low_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !filt_en_o);
  a_r2_load_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(filt_en_o) |-> !cmd_valid_o && !left_rd_o && !left_wr_o);
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_en_o && start_i && !cmd_valid_o && $stable(filt_en_o)) |=> (filt_en_o || done_o));

endmodule

// File: tb/deblk_sched_bench.sv
`timescale 1ns/1ps
module deblk_sched_bench;
  localparam int N_EDGE = 48;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         top_frame_i = 1'b0;
  logic [143:0] bs_i = '0;
  logic         cmd_valid_o, dir_o, left_rd_o, left_wr_o, filt_en_o, done_o;
  logic [5:0]   edge_idx_o;
  logic [1:0]   plane_o;
  logic [2:0]   bs_o;
  logic [4:0]   left_addr_o;
  logic [8:0]   cycles_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  deblk_sched u_deblk_sched (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .top_frame_i(top_frame_i),
    .bs_i(bs_i), .cmd_valid_o(cmd_valid_o), .edge_idx_o(edge_idx_o),
    .plane_o(plane_o), .dir_o(dir_o), .bs_o(bs_o), .left_rd_o(left_rd_o),
    .left_wr_o(left_wr_o), .left_addr_o(left_addr_o), .filt_en_o(filt_en_o),
    .done_o(done_o), .cycles_o(cycles_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  function automatic int f_base(int e);
    return (e < 32) ? 0 : (e < 40) ? 32 : 40;
  endfunction
  function automatic int f_plane(int e);
    return (e < 32) ? 0 : (e < 40) ? 1 : 2;
  endfunction
  function automatic int f_side(int e);
    return (e < 32) ? 4 : 2;
  endfunction
  function automatic int f_dir(int e);
    return (e - f_base(e)) % 2;
  endfunction
  function automatic int f_row(int e);
    return ((e - f_base(e)) / 2) / f_side(e);
  endfunction
  function automatic int f_col(int e);
    return ((e - f_base(e)) / 2) % f_side(e);
  endfunction
  function automatic int f_bs(logic [143:0] bs, int e);
    return int'(bs[e*3 +: 3]);
  endfunction
  function automatic bit f_skip(logic [143:0] bs, bit top, int e);
    if (e >= N_EDGE) return 1'b0;
    return (f_dir(e) == 1) && (f_bs(bs, e) == 0 || (top && f_row(e) == 0));
  endfunction
  function automatic int f_wbase(int e);
    return (f_plane(e) == 0) ? 0 : (f_plane(e) == 1) ? 16 : 24;
  endfunction

  task automatic run_mb(input logic [143:0] bs, input bit top, input int spur);
    int exp_e[N_EDGE];
    int n = 0;
    for (int e = 0; e < N_EDGE; e++)
      if (!f_skip(bs, top, e)) begin exp_e[n] = e; n++; end
    @(negedge clk);
    bs_i = bs; top_frame_i = top; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; ; c++) begin
      start_i = (c == spur);
      if (c > 4 + 4 * N_EDGE + 8) begin
        chk(1'b0, "R7 schedule overrun", c, 4 + 4 * n);
        break;
      end
      if (c == 4 + 4 * n) begin
        chk(done_o == 1'b1, "R8 done", int'(done_o), 1);
        chk(filt_en_o == 1'b0, "R8 enable off", int'(filt_en_o), 0);
        chk(int'(cycles_o) == 4 + 4 * n, "R7 cycle count", int'(cycles_o), 4 + 4 * n);
        break;
      end
      chk(filt_en_o == 1'b1 && done_o == 1'b0, "R2/R8 busy", int'({filt_en_o, done_o}), 2);
      if (c < 4) begin
        chk(!cmd_valid_o && !left_rd_o && !left_wr_o, "R2 load window",
            int'({cmd_valid_o, left_rd_o, left_wr_o}), 0);
      end else begin
        int j, ph, e;
        bit erd, ewr;
        j  = (c - 4) / 4;
        ph = (c - 4) % 4;
        e  = exp_e[j];
        chk(cmd_valid_o == (ph == 0), "R6 strobe", int'(cmd_valid_o), int'(ph == 0));
        chk(int'(edge_idx_o) == e, "R3/R4 edge index", int'(edge_idx_o), e);
        if (ph == 0) begin
          chk(int'(plane_o) == f_plane(e), "R3 plane", int'(plane_o), f_plane(e));
          chk(int'(dir_o) == f_dir(e), "R3 direction", int'(dir_o), f_dir(e));
          chk(int'(bs_o) == f_bs(bs, e), "R5 strength", int'(bs_o), f_bs(bs, e));
        end
        erd = (f_dir(e) == 0) && (f_col(e) == 0);
        ewr = (f_col(e) == f_side(e) - 1) && (f_dir(e) == 1 || f_skip(bs, top, e + 1));
        chk(left_rd_o == erd, "R10 left read", int'(left_rd_o), int'(erd));
        chk(left_wr_o == ewr, "R11 left write", int'(left_wr_o), int'(ewr));
        if (erd || ewr)
          chk(int'(left_addr_o) == f_wbase(e) + 4 * f_row(e) + ph, "R10 address",
              int'(left_addr_o), f_wbase(e) + 4 * f_row(e) + ph);
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    @(negedge clk);
    chk(!filt_en_o && !done_o && !cmd_valid_o, "R9 idle after done",
        int'({filt_en_o, done_o, cmd_valid_o}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [143:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!cmd_valid_o && !filt_en_o && !done_o && !left_rd_o && !left_wr_o,
        "R1 in reset", 1, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!cmd_valid_o && !filt_en_o && !done_o && !left_rd_o && !left_wr_o,
        "R1 after reset", 1, 0);

    // all strong, nothing skipped: 196
    for (int e = 0; e < N_EDGE; e++) v[e*3 +: 3] = 3'd4;
    run_mb(v, 1'b0, -1);
    // every horizontal edge zero: 100
    for (int e = 0; e < N_EDGE; e++) v[e*3 +: 3] = (f_dir(e) == 1) ? 3'd0 : 3'd2;
    run_mb(v, 1'b0, -1);
    run_mb(v, 1'b1, 9);
    // top-of-frame only
    for (int e = 0; e < N_EDGE; e++) v[e*3 +: 3] = 3'd3;
    run_mb(v, 1'b1, -1);
    // vertical zero still issued (R5)
    for (int e = 0; e < N_EDGE; e++) v[e*3 +: 3] = (f_dir(e) == 0) ? 3'd0 : 3'd1;
    run_mb(v, 1'b0, 30);
    // last Cr horizontal edge skipped
    for (int e = 0; e < N_EDGE; e++) v[e*3 +: 3] = 3'd1;
    v[47*3 +: 3] = 3'd0;
    run_mb(v, 1'b0, -1);
    // random mix
    for (int r = 0; r < 20; r++) begin
      for (int e = 0; e < N_EDGE; e++) begin
        if (f_dir(e) == 1 && $urandom_range(1, 0) == 0) v[e*3 +: 3] = 3'd0;
        else v[e*3 +: 3] = 3'($urandom_range(4, 0));
      end
      run_mb(v, 1'($urandom_range(1, 0)), (r % 3 == 0) ? int'($urandom_range(60, 5)) : -1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule